// File: doc/BRIEF.md
# Bit-Plane Erasure Threshold Unit

This unit screens one code block of high-frequency sub-band coefficients that were read back from a tile memory prone to bit errors, before they reach the entropy coder. It takes the block twice over a valid/ready stream. During the first pass it counts the set bits of every bit plane in parallel. It then decides which of the most significant planes look like noise and should be cleared. During the second pass it forwards the coefficients with those planes forced to zero. A per-plane flag vector marks every cleared plane as all-zero, so the coder can skip it.

Two policies are available. In the adaptive policy the limit is twice the expected number of erroneous bits in a plane. Planes are tested from the top down, and testing ends for good at the first plane whose count reaches the limit. In the fixed policy a configured number of top planes, two to four, is cleared whatever the counts. Under both policies a candidate-plane limit bounds how far down clearing may reach. The configuration is captured when a block starts.

Both stream interfaces follow the usual valid/ready rules. A beat transfers on a clock edge where valid and ready are both high. The data must stay stable while valid is high and ready is low. During the counting pass the unit is always ready. During the output pass the input ready follows the output ready and the output valid follows the input valid, so back-pressure from downstream stalls the upstream source directly.

Top module: `bp_erase_unit`

## Requirements
- R1: After an accepted start, the unit accepts exactly NCOEF input beats with in_ready_o high and out_valid_o low. It then holds in_ready_o low for one cycle before the output pass.
- R2: Each plane's count of set bits is held in a CNT_W-bit (9-bit) counter that saturates at 511 instead of wrapping.
- R3: In the adaptive policy (simple_mode_i = 0), the limit is 2 × exp_err_i and a plane is cleared only if its count is strictly below the limit. A count equal to the limit keeps the plane, and an expected count of 0 clears nothing.
- R4: Planes are tested from bit 15 downward. The first plane that is kept ends testing, and every lower plane passes unchanged whatever its count.
- R5: Only the top cand_planes_i planes (bits 15 down to 16 − cand_planes_i) may be cleared. A value of 0 clears nothing, and values above 16 act as 16.
- R6: In the fixed policy (simple_mode_i = 1), the top n planes are cleared regardless of the counts, still within the R5 limit. n is simple_planes_i, raised to 2 if smaller and lowered to 4 if larger.
- R7: On every output beat, out_data_o equals the input coefficient with the cleared bit positions at zero. During the output pass, out_valid_o equals in_valid_i and in_ready_o equals out_ready_i.
- R8: Bit p of zero_plane_o is 1 exactly when plane p was cleared. It is valid from the first cycle of the output pass until the next accepted start, and it is 0 while counting and after reset.
- R9: done_o is a one-cycle pulse in the cycle after the last output handshake.
- R10: A start request while a block is in progress is ignored. The configuration inputs are captured only when a start is accepted.
- R11: After reset, in_ready_o, out_valid_o, done_o and zero_plane_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a block, taken only when idle |
| simple_mode_i | input | 1 | 1 selects the fixed policy, 0 the adaptive one |
| simple_planes_i | input | 3 | Number of top planes cleared in the fixed policy (clamped 2..4) |
| exp_err_i | input | CNT_W-1 | Expected erroneous bits per plane |
| cand_planes_i | input | LIM_W | Number of top planes eligible for clearing |
| in_valid_i | input | 1 | Input coefficient valid |
| in_ready_o | output | 1 | Input coefficient ready |
| in_data_i | input | DATA_W | Input coefficient |
| out_valid_o | output | 1 | Output coefficient valid |
| out_ready_i | input | 1 | Output coefficient ready |
| out_data_o | output | DATA_W | Coefficient with cleared planes masked |
| zero_plane_o | output | DATA_W | Per-plane all-zero flags |
| done_o | output | 1 | Block finished pulse |

## Verification
The bench builds the unit with NCOEF = 600 and leaves the 16-bit data width and the 9-bit counters at their defaults. Because a block is longer than 511 coefficients, a plane that is set in every coefficient drives its counter into saturation. Against a limit of 510 this separates saturation from wrap-around in a single block. The small block also keeps many runs with stalls on both streams within a short run, which covers the strict-less-than boundary, the stop-at-first-kept rule, the candidate limit and the fixed-policy clamping.

// File: rtl/bp_erase_pkg.sv
package bp_erase_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_COUNT  = 2'd1,
    ST_DECIDE = 2'd2,
    ST_EMIT   = 2'd3
  } bp_state_e;

  localparam int SIMPLE_MIN = 2;
  localparam int SIMPLE_MAX = 4;

  function automatic int clamp_simple(input int v);
    if (v < SIMPLE_MIN) return SIMPLE_MIN;
    if (v > SIMPLE_MAX) return SIMPLE_MAX;
    return v;
  endfunction

endpackage

// File: rtl/bp_plane_counter.sv
module bp_plane_counter #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (inc_i && (cnt_q != CNT_MAX)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !clr_i) |=> (cnt_q == CNT_MAX)); // R2
  AST_NO_DECREASE: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (cnt_q >= $past(cnt_q))); // R2

endmodule

// File: rtl/bp_erase_decider.sv
module bp_erase_decider
  import bp_erase_pkg::*;
#(
  parameter int PLANES = 16,
  parameter int CNT_W  = 9,
  parameter int LIM_W  = 5,
  parameter int SN_W   = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr_i,
  input  logic                          load_i,
  input  logic [PLANES-1:0][CNT_W-1:0]  cnt_i,
  input  logic [CNT_W-1:0]              thr_i,
  input  logic                          simple_i,
  input  logic [SN_W-1:0]               simple_n_i,
  input  logic [LIM_W-1:0]              cand_i,
  output logic [PLANES-1:0]             mask_o
);
  logic [PLANES-1:0] mask_d;
  logic [PLANES-1:0] mask_q;
  logic              go;
  int                lim_v;
  int                n_v;

  always_comb begin
    mask_d = '0;
    go     = 1'b1;
    lim_v  = (int'(cand_i) > PLANES) ? PLANES : int'(cand_i);
    n_v    = clamp_simple(int'(simple_n_i));
    for (int p = PLANES - 1; p >= 0; p--) begin
      if (simple_i) begin
        mask_d[p] = (p >= PLANES - lim_v) && (p >= PLANES - n_v);
      end else begin
        mask_d[p] = go && (p >= PLANES - lim_v) && (cnt_i[p] < thr_i);
        go        = mask_d[p];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (clr_i) begin
      mask_q <= '0;
    end else if (load_i) begin
      mask_q <= mask_d;
    end
  end

  assign mask_o = mask_q;

  for (genvar g = 0; g < PLANES; g++) begin : g_chk
    AST_ERASE_BELOW_THR: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q[g] && !simple_i) |-> (cnt_i[g] < thr_i)); // R3
    if (g < PLANES - 1) begin : g_chain
      AST_TOP_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
        mask_q[g] |-> mask_q[g+1]); // R4
    end
  end

endmodule

// File: rtl/bp_seq_ctrl.sv
module bp_seq_ctrl
  import bp_erase_pkg::*;
#(
  parameter int NCOEF = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic in_valid_i,
  input  logic out_ready_i,
  output logic in_ready_o,
  output logic out_valid_o,
  output logic start_acc_o,
  output logic count_hs_o,
  output logic load_o,
  output logic done_o
);
  localparam int IDX_W = (NCOEF > 1) ? $clog2(NCOEF) : 1;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NCOEF - 1);

  bp_state_e        state_q;
  logic [IDX_W-1:0] idx_q;
  logic             done_q;
  logic             emit_hs;

  assign start_acc_o = (state_q == ST_IDLE) && start_i;
  assign in_ready_o  = (state_q == ST_COUNT) || ((state_q == ST_EMIT) && out_ready_i);
  assign out_valid_o = (state_q == ST_EMIT) && in_valid_i;
  assign count_hs_o  = (state_q == ST_COUNT) && in_valid_i;
  assign emit_hs     = (state_q == ST_EMIT) && in_valid_i && out_ready_i;
  assign load_o      = (state_q == ST_DECIDE);
  assign done_o      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_COUNT;
            idx_q   <= '0;
          end
        end
        ST_COUNT: begin
          if (in_valid_i) begin
            if (idx_q == IDX_LAST) begin
              state_q <= ST_DECIDE;
              idx_q   <= '0;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_DECIDE: begin
          state_q <= ST_EMIT;
        end
        ST_EMIT: begin
          if (emit_hs) begin
            if (idx_q == IDX_LAST) begin
              state_q <= ST_IDLE;
              idx_q   <= '0;
              done_q  <= 1'b1;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R9
  AST_DONE_FROM_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(state_q) == ST_EMIT)); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_COUNT && !in_valid_i) |=> (state_q == ST_COUNT && $stable(idx_q))); // R10
  AST_DECIDE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DECIDE) |=> (state_q == ST_EMIT)); // R1

endmodule

// File: rtl/bp_erase_unit.sv
module bp_erase_unit
  import bp_erase_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 9,
  parameter int NCOEF  = 1024,
  parameter int LIM_W  = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              simple_mode_i,
  input  logic [2:0]        simple_planes_i,
  input  logic [CNT_W-2:0]  exp_err_i,
  input  logic [LIM_W-1:0]  cand_planes_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic [DATA_W-1:0] zero_plane_o,
  output logic              done_o
);
  logic                         start_acc;
  logic                         count_hs;
  logic                         load;
  logic [DATA_W-1:0][CNT_W-1:0] plane_cnt;
  logic [DATA_W-1:0]            mask;

  logic                         simple_q;
  logic [2:0]                   sn_q;
  logic [CNT_W-2:0]             exp_q;
  logic [LIM_W-1:0]             cand_q;
  logic [CNT_W-1:0]             thr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      simple_q <= 1'b0;
      sn_q     <= '0;
      exp_q    <= '0;
      cand_q   <= '0;
    end else if (start_acc) begin
      simple_q <= simple_mode_i;
      sn_q     <= simple_planes_i;
      exp_q    <= exp_err_i;
      cand_q   <= cand_planes_i;
    end
  end

  assign thr = {exp_q, 1'b0};

  bp_seq_ctrl #(.NCOEF(NCOEF)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .in_valid_i  (in_valid_i),
    .out_ready_i (out_ready_i),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .start_acc_o (start_acc),
    .count_hs_o  (count_hs),
    .load_o      (load),
    .done_o      (done_o)
  );

  for (genvar p = 0; p < DATA_W; p++) begin : g_plane
    bp_plane_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (start_acc),
      .inc_i (count_hs && in_data_i[p]),
      .cnt_o (plane_cnt[p])
    );
  end

  bp_erase_decider #(
    .PLANES (DATA_W),
    .CNT_W  (CNT_W),
    .LIM_W  (LIM_W),
    .SN_W   (3)
  ) u_decide (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (start_acc),
    .load_i     (load),
    .cnt_i      (plane_cnt),
    .thr_i      (thr),
    .simple_i   (simple_q),
    .simple_n_i (sn_q),
    .cand_i     (cand_q),
    .mask_o     (mask)
  );

  assign out_data_o   = in_data_i & ~mask;
  assign zero_plane_o = mask;

  AST_OUT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid_o |-> ((out_data_o & zero_plane_o) == '0)); // R7
  AST_FLAGS_CLEAR_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (zero_plane_o == '0)); // R8

endmodule

// File: tb/bp_erase_unit_tb_top.sv
module bp_erase_unit_tb_top;
  localparam int DW = 16;
  localparam int CW = 9;
  localparam int N  = 600;
  localparam int LW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          simple_mode_i = 1'b0;
  logic [2:0]    simple_planes_i = '0;
  logic [CW-2:0] exp_err_i = '0;
  logic [LW-1:0] cand_planes_i = '0;
  logic          in_valid_i = 1'b0;
  logic          in_ready_o;
  logic [DW-1:0] in_data_i = '0;
  logic          out_valid_o;
  logic          out_ready_i = 1'b0;
  logic [DW-1:0] out_data_o;
  logic [DW-1:0] zero_plane_o;
  logic          done_o;

  always #10 clk = ~clk;

  bp_erase_unit #(.DATA_W(DW), .CNT_W(CW), .NCOEF(N)) dut_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .simple_mode_i   (simple_mode_i),
    .simple_planes_i (simple_planes_i),
    .exp_err_i       (exp_err_i),
    .cand_planes_i   (cand_planes_i),
    .in_valid_i      (in_valid_i),
    .in_ready_o      (in_ready_o),
    .in_data_i       (in_data_i),
    .out_valid_o     (out_valid_o),
    .out_ready_i     (out_ready_i),
    .out_data_o      (out_data_o),
    .zero_plane_o    (zero_plane_o),
    .done_o          (done_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] blk [N];
  int tgt [DW];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fill_block();
    for (int i = 0; i < N; i++)
      for (int p = 0; p < DW; p++)
        blk[i][p] = (((7 * i + 13 * p) % N) < tgt[p]);
  endtask

  function automatic logic [DW-1:0] model_mask(input bit simple, input int sn,
                                               input int ex, input int cand);
    logic [DW-1:0] m = '0;
    int cnt [DW];
    int lim = (cand > DW) ? DW : cand;
    int n = (sn < 2) ? 2 : ((sn > 4) ? 4 : sn);
    int thr = 2 * ex;
    for (int p = 0; p < DW; p++) begin
      cnt[p] = 0;
      for (int i = 0; i < N; i++) if (blk[i][p]) cnt[p]++;
      if (cnt[p] > 511) cnt[p] = 511;
    end
    if (simple) begin
      for (int k = 0; k < n && k < lim; k++) m[DW-1-k] = 1'b1;
    end else begin
      for (int k = 0; k < lim; k++) begin
        if (cnt[DW-1-k] < thr) m[DW-1-k] = 1'b1;
        else break;
      end
    end
    return m;
  endfunction

  task automatic run_block(input string tag, input bit simple, input int sn,
                           input int ex, input int cand, input bit inject);
    logic [DW-1:0] em;
    int k;
    int i;
    em = model_mask(simple, sn, ex, cand);
    @(negedge clk);
    simple_mode_i = simple;
    simple_planes_i = 3'(sn);
    exp_err_i = 8'(ex);
    cand_planes_i = 5'(cand);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    #1;
    chk(in_ready_o == 1'b1, {tag, " R1 ready in count"}, in_ready_o, 1);
    chk(zero_plane_o == '0, {tag, " R8 flags clear while counting"}, zero_plane_o, 0);
    // counting pass with occasional gaps
    for (int j = 0; j < N; j++) begin
      if (j % 9 == 4) begin
        in_valid_i = 1'b0;
        @(negedge clk);
      end
      in_valid_i = 1'b1;
      in_data_i = blk[j];
      if (inject && j == 10) begin
        start_i = 1'b1;
        simple_mode_i = ~simple;
        simple_planes_i = 3'd4;
        exp_err_i = 8'd200;
        cand_planes_i = 5'd16;
      end else begin
        start_i = 1'b0;
      end
      #1;
      chk(out_valid_o == 1'b0 && in_ready_o == 1'b1, {tag, " R1 count beat"},
          {out_valid_o, in_ready_o}, 2'b01);
      @(negedge clk);
    end
    start_i = 1'b0;
    in_valid_i = 1'b0;
    #1;
    chk(in_ready_o == 1'b0, {tag, " R1 decide cycle not ready"}, in_ready_o, 0);
    @(negedge clk);
    #1;
    chk(zero_plane_o == em, {tag, " flags"}, zero_plane_o, em);
    // output pass with stalls on both sides
    k = 0;
    i = 0;
    while (i < N) begin
      in_valid_i = (k % 5 != 3);
      out_ready_i = (k % 7 != 2);
      in_data_i = blk[i];
      #1;
      chk(out_valid_o == in_valid_i && in_ready_o == out_ready_i, {tag, " R7 handshake"},
          {out_valid_o, in_ready_o}, {in_valid_i, out_ready_i});
      if (in_valid_i && out_ready_i) begin
        chk(out_data_o == (blk[i] & ~em), {tag, " R7 data"}, out_data_o, blk[i] & ~em);
        i++;
      end
      k++;
      @(negedge clk);
    end
    in_valid_i = 1'b0;
    out_ready_i = 1'b0;
    #1;
    chk(done_o == 1'b1, {tag, " R9 done pulse"}, done_o, 1);
    chk(zero_plane_o == em, {tag, " R8 flags held"}, zero_plane_o, em);
    @(negedge clk);
    #1;
    chk(done_o == 1'b0, {tag, " R9 done single cycle"}, done_o, 0);
  endtask

  task automatic set_tgt(input int top15, input int top14, input int top13,
                         input int top12, input int rest);
    tgt[15] = top15; tgt[14] = top14; tgt[13] = top13; tgt[12] = top12;
    for (int p = 0; p < 12; p++) tgt[p] = rest;
    fill_block();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(in_ready_o == 0 && out_valid_o == 0 && done_o == 0 && zero_plane_o == 0,
        "R11 reset state", {in_ready_o, out_valid_o, done_o, zero_plane_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(in_ready_o == 0 && zero_plane_o == 0, "R11 idle after reset",
        {in_ready_o, zero_plane_o}, 0);

    // R3 R4: limit 6, planes 15 (2) and 14 (5) cleared, 13 (7) kept, 11 (0) not reached
    set_tgt(2, 5, 7, 100, 0);
    tgt[10] = 300;
    fill_block();
    run_block("R4 stop at first kept", 1'b0, 0, 3, 6, 1'b0);
    // R3 boundary: 5 < 6 cleared, 6 == 6 kept
    set_tgt(5, 6, 0, 0, 250);
    run_block("R3 strict boundary", 1'b0, 0, 3, 16, 1'b0);
    // R3: expected count 0 clears nothing
    set_tgt(0, 0, 0, 0, 0);
    run_block("R3 zero limit", 1'b0, 0, 0, 16, 1'b0);
    // R2: 509 < 510 cleared, 600 saturates to 511 and is kept
    set_tgt(509, 600, 0, 0, 300);
    run_block("R2 saturation", 1'b0, 0, 255, 16, 1'b0);
    // R5: candidate limits
    set_tgt(0, 0, 0, 0, 0);
    run_block("R5 limit two", 1'b0, 0, 3, 2, 1'b0);
    run_block("R5 limit zero", 1'b0, 0, 3, 0, 1'b0);
    run_block("R5 limit above range", 1'b0, 0, 3, 20, 1'b0);
    // R6: fixed policy ignores counts, clamps 2..4
    set_tgt(400, 400, 400, 400, 400);
    run_block("R6 fixed three", 1'b1, 3, 0, 16, 1'b0);
    run_block("R6 fixed clamp low", 1'b1, 1, 0, 16, 1'b0);
    run_block("R6 fixed clamp high", 1'b1, 7, 0, 16, 1'b0);
    run_block("R6 fixed within limit", 1'b1, 4, 0, 3, 1'b0);
    // R10: start and new configuration during a block are ignored
    set_tgt(2, 5, 7, 100, 50);
    run_block("R10 start ignored", 1'b0, 0, 3, 6, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule